// File: doc/BRIEF.md
# Divider-Free Sum Normalizer

This block scales four unsigned samples by the total of the group, so each output is the share of that lane in the sum, written as a 16-bit unsigned fraction. No divider is built. The 18-bit total is reduced to a short six-bit mantissa taken just below and including its leading one. That mantissa selects an 8-bit reciprocal from a small computed table, and each lane is multiplied by that reciprocal. A shift then takes out the power-of-two scale, using the leading-one position.

The table entries are computed so that rounding only ever makes a result smaller. Each result is a slight underestimate of the exact share and can never reach 1.0. The datapath is a fixed four-stage pipeline. It accepts a new group on every clock. A valid flag travels alongside the data, so a group may be presented on any cycle and gaps between groups are allowed.

Top module: `recip_normalizer`

## Requirements
- R1: The total is the full-precision sum of all four lanes, held in 18 bits, so it never wraps. With every lane at 65535, each output is 16383.
- R2: Let p be the bit position of the leading one of the total S. The six-bit table index is bits 17..12 of S shifted left by (17 - p). When S has fewer than six significant bits, the low bits of the index are zero.
- R3: The table entry for index w (32..63) is floor(8192 / (w + 1)). That is the reciprocal of the largest total that maps to w, rounded down, in 8 bits.
- R4: Lane i's input sits in bits 16i+15..16i of `in_data`, and its output sits in the same bits of `out_frac`. For a nonzero total, the output is bits 15..0 of ((x * entry) * 256) >> p.
- R5: Whenever x > 0, out * S < x * 65536. The output never reaches or exceeds the exact fraction x/S scaled by 65536. A lane with x = 0 gives 0.
- R6: When the total is zero, all four outputs are zero.
- R7: A group is accepted on every clock with `in_valid` high. `out_valid` equals `in_valid` delayed by four clocks and carries that group's results. After reset, `out_valid` is low and `out_frac` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` on this cycle |
| in_data | input | 64 | Four unsigned 16-bit samples, lane i in bits 16i+15..16i |
| out_valid | output | 1 | Qualifies `out_frac`, four clocks after the matching input |
| out_frac | output | 64 | Four unsigned 16-bit fractions, lane i in bits 16i+15..16i |

## Verification
The main function is driven with totals built from each table index at leading-one positions 5, 12 and 17. These show whether the table and the shift stay correct across the full range of magnitudes. Every total from 1 to 63 is also applied, both in a single lane and spread across lanes. These small totals exercise the zero-padded index and the left-shift path, which large totals never reach. Several further cases separate the remaining paths:
- all-zero groups,
- a single saturated lane,
- all lanes at full scale,
- thousands of pseudo-random groups with varied magnitude.

These cases separate correct wrap-free summation and zero handling from the general multiply-and-shift path. Gaps in `in_valid` confirm that the valid flag and the data stay aligned while groups stream every clock.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

    // Reciprocal of the largest total that falls on an index, floored.
    // Indices without a leading one in the top bit are never used and read zero.
    function automatic int recip_entry(input int idx, input int idx_w, input int k);
        if (idx < (1 << (idx_w - 1))) begin
            return 0;
        end
        return (1 << k) / (idx + 1);
    endfunction

endpackage

// File: rtl/nrm_lead_window.sv
module nrm_lead_window #(
    parameter int SUM_W = 18,
    parameter int IDX_W = 6,
    localparam int POS_W = $clog2(SUM_W)
) (
    input  logic [SUM_W-1:0] sum,
    output logic [POS_W-1:0] pos,
    output logic [IDX_W-1:0] idx,
    output logic             zero
);
    logic [SUM_W-1:0] aligned;

    always_comb begin
        pos = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (sum[i]) begin
                pos = POS_W'(i);
            end
        end
        zero    = (sum == '0);
        aligned = sum << (POS_W'(SUM_W - 1) - pos);
        idx     = aligned[SUM_W-1 -: IDX_W];
    end
endmodule

// File: rtl/nrm_recip_rom.sv
module nrm_recip_rom #(
    parameter int IDX_W = 6,
    parameter int RCP_W = 8,
    localparam int K = RCP_W + IDX_W - 1,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    output logic [RCP_W-1:0] rcp
);
    logic [RCP_W-1:0] table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_q[g] = RCP_W'(nrm_pkg::recip_entry(g, IDX_W, K));
    end

    assign rcp = table_q[idx];
endmodule

// File: rtl/nrm_lane_scale.sv
module nrm_lane_scale #(
    parameter int PROD_W = 24,
    parameter int OUT_W  = 16,
    parameter int LSH0   = 8,
    parameter int POS_W  = 5,
    localparam int WIDE_W = PROD_W + LSH0
) (
    input  logic [PROD_W-1:0] prod,
    input  logic [POS_W-1:0]  pos,
    input  logic              zero,
    output logic [OUT_W-1:0]  frac
);
    logic [WIDE_W-1:0] wide;

    always_comb begin
        wide = WIDE_W'(prod) << LSH0;
        wide = wide >> pos;
        frac = zero ? '0 : wide[OUT_W-1:0];
    end
endmodule

// File: rtl/recip_normalizer.sv
module recip_normalizer #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 6,
    parameter int RCP_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*DATA_W-1:0] in_data,
    output logic                    out_valid,
    output logic [LANES*DATA_W-1:0] out_frac
);
    localparam int SUM_W  = DATA_W + $clog2(LANES);
    localparam int POS_W  = $clog2(SUM_W);
    localparam int K      = RCP_W + IDX_W - 1;
    localparam int LSH0   = DATA_W + IDX_W - 1 - K;
    localparam int PROD_W = DATA_W + RCP_W;

    typedef struct packed {
        logic                          valid;
        logic [LANES-1:0][DATA_W-1:0]  x;
        logic [SUM_W-1:0]              sum;
    } st_sum_t;

    typedef struct packed {
        logic                          valid;
        logic [LANES-1:0][DATA_W-1:0]  x;
        logic [RCP_W-1:0]              rcp;
        logic [POS_W-1:0]              pos;
        logic                          zero;
    } st_lut_t;

    typedef struct packed {
        logic                          valid;
        logic [LANES-1:0][PROD_W-1:0]  prod;
        logic [POS_W-1:0]              pos;
        logic                          zero;
    } st_mul_t;

    typedef struct packed {
        logic                          valid;
        logic [LANES-1:0][DATA_W-1:0]  frac;
    } st_out_t;

    typedef struct packed {
        st_sum_t s1;
        st_lut_t s2;
        st_mul_t s3;
        st_out_t s4;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [POS_W-1:0]             lw_pos;
    logic [IDX_W-1:0]             lw_idx;
    logic                         lw_zero;
    logic [RCP_W-1:0]             rom_rcp;
    logic [LANES-1:0][DATA_W-1:0] lane_frac;

    nrm_lead_window #(.SUM_W(SUM_W), .IDX_W(IDX_W)) u_window (
        .sum  (pipe_q.s1.sum),
        .pos  (lw_pos),
        .idx  (lw_idx),
        .zero (lw_zero)
    );

    nrm_recip_rom #(.IDX_W(IDX_W), .RCP_W(RCP_W)) u_rom (
        .idx (lw_idx),
        .rcp (rom_rcp)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        nrm_lane_scale #(
            .PROD_W (PROD_W),
            .OUT_W  (DATA_W),
            .LSH0   (LSH0),
            .POS_W  (POS_W)
        ) u_scale (
            .prod (pipe_q.s3.prod[l]),
            .pos  (pipe_q.s3.pos),
            .zero (pipe_q.s3.zero),
            .frac (lane_frac[l])
        );
    end

    always_comb begin
        pipe_d = pipe_q;

        // stage 1: capture lanes and form the wide total
        pipe_d.s1.valid = in_valid;
        pipe_d.s1.sum   = '0;
        for (int l = 0; l < LANES; l++) begin
            pipe_d.s1.x[l] = in_data[l*DATA_W +: DATA_W];
            pipe_d.s1.sum  = pipe_d.s1.sum + SUM_W'(in_data[l*DATA_W +: DATA_W]);
        end

        // stage 2: leading one and reciprocal lookup
        pipe_d.s2.valid = pipe_q.s1.valid;
        pipe_d.s2.x     = pipe_q.s1.x;
        pipe_d.s2.rcp   = rom_rcp;
        pipe_d.s2.pos   = lw_pos;
        pipe_d.s2.zero  = lw_zero;

        // stage 3: one multiply per lane
        pipe_d.s3.valid = pipe_q.s2.valid;
        pipe_d.s3.pos   = pipe_q.s2.pos;
        pipe_d.s3.zero  = pipe_q.s2.zero;
        for (int l = 0; l < LANES; l++) begin
            pipe_d.s3.prod[l] = PROD_W'(pipe_q.s2.x[l]) * PROD_W'(pipe_q.s2.rcp);
        end

        // stage 4: remove the scale
        pipe_d.s4.valid = pipe_q.s3.valid;
        pipe_d.s4.frac  = lane_frac;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s4.valid;
    assign out_frac  = pipe_q.s4.frac;
endmodule

// File: rtl/nrm_checker.sv
module nrm_checker #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [LANES*DATA_W-1:0] in_data,
    input logic                    out_valid,
    input logic [LANES*DATA_W-1:0] out_frac
);
    localparam int SUM_W = DATA_W + $clog2(LANES);

    logic [3:0]                    v_q;
    logic [LANES*DATA_W-1:0]       d_q [4];
    logic [SUM_W-1:0]              tot;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
            for (int i = 0; i < 4; i++) d_q[i] <= '0;
        end else begin
            v_q <= {v_q[2:0], in_valid};
            d_q[0] <= in_data;
            for (int i = 1; i < 4; i++) d_q[i] <= d_q[i-1];
        end
    end

    always_comb begin
        tot = '0;
        for (int l = 0; l < LANES; l++) begin
            tot = tot + SUM_W'(d_q[3][l*DATA_W +: DATA_W]);
        end
    end

    // R7: valid emerges exactly four clocks after it entered
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_q[3]);

    // R6: an empty group gives all-zero fractions
    a_r6_zero_sum: assert property (@(posedge clk) disable iff (rst)
        (out_valid && tot == '0) |-> (out_frac == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        logic [63:0] lhs, rhs;
        assign lhs = 64'(out_frac[l*DATA_W +: DATA_W]) * 64'(tot);
        assign rhs = 64'(d_q[3][l*DATA_W +: DATA_W]) << DATA_W;

        // R5: strictly below the exact share
        a_r5_below_one: assert property (@(posedge clk) disable iff (rst)
            (out_valid && rhs != 0) |-> (lhs < rhs));

        // R5: a silent lane reads zero
        a_r5_zero_lane: assert property (@(posedge clk) disable iff (rst)
            (out_valid && rhs == 0) |-> (out_frac[l*DATA_W +: DATA_W] == '0));

        if (l + 1 < LANES) begin : g_order
            // R4: one shared reciprocal keeps lane ordering
            a_r4_lane_order: assert property (@(posedge clk) disable iff (rst)
                (out_valid && d_q[3][l*DATA_W +: DATA_W] >= d_q[3][(l+1)*DATA_W +: DATA_W])
                |-> (out_frac[l*DATA_W +: DATA_W] >= out_frac[(l+1)*DATA_W +: DATA_W]));
        end
    end
endmodule

bind recip_normalizer nrm_checker #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_frac  (out_frac)
);

// File: tb/recip_normalizer_bench.sv
module recip_normalizer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV       = 4096;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_frac;

    recip_normalizer u_recip_normalizer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_frac  (out_frac)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_checks = 0;
    int          n_fail   = 0;
    int          wr = 0;
    int          rd = 0;
    int          cycles = 0;
    bit          done = 1'b0;
    logic [63:0] exp_mem [MAXV];
    logic [63:0] in_mem  [MAXV];
    string       tag_mem [MAXV];
    logic [2:0]  vh = '0;
    logic [31:0] rng = 32'h1234_5679;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic longint exp_frac(input longint x, input longint s);
        int p;
        longint w, r, v;
        if (s == 0) return 0;
        p = 0;
        for (int i = 0; i < 18; i++) if (s[i]) p = i;
        w = ((s << (17 - p)) >> 12) & 63;
        r = 8192 / (w + 1);
        v = x * r;
        if (p >= 8) v = v >> (p - 8);
        else v = v << (8 - p);
        return v & 16'hFFFF;
    endfunction

    task automatic send(input longint a, input longint b, input longint c, input longint d, input string tag);
        longint s;
        logic [63:0] e;
        s = a + b + c + d;
        e = {16'(exp_frac(d, s)), 16'(exp_frac(c, s)), 16'(exp_frac(b, s)), 16'(exp_frac(a, s))};
        exp_mem[wr] = e;
        in_mem[wr]  = {16'(d), 16'(c), 16'(b), 16'(a)};
        tag_mem[wr] = tag;
        @(negedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = {16'(d), 16'(c), 16'(b), 16'(a)};
        wr++;
    endtask

    task automatic bubble();
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        in_data  = {rng, ~rng};
    endtask

    task automatic spread(input longint s, input string tag);
        longint q;
        q = s / 4;
        send(q, q, q, s - 3*q, tag);
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        logic [31:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // monitor: valid alignment and data compare
    always @(negedge clk) begin
        if (rst) begin
            vh <= '0;
        end else if (!done) begin
            check(out_valid == vh[2], "R7 valid latency", longint'(out_valid), longint'(vh[2]));
            if (out_valid) begin
                for (int l = 0; l < 4; l++) begin
                    longint a, e, x, s;
                    a = longint'(out_frac[16*l +: 16]);
                    e = longint'(exp_mem[rd][16*l +: 16]);
                    x = longint'(in_mem[rd][16*l +: 16]);
                    s = longint'(in_mem[rd][15:0]) + longint'(in_mem[rd][31:16])
                      + longint'(in_mem[rd][47:32]) + longint'(in_mem[rd][63:48]);
                    check(a == e, tag_mem[rd], a, e);
                    if (x > 0) check(a * s < (x << 16), "R5 below one", a * s, x << 16);
                end
                rd++;
            end
            vh <= {vh[1:0], in_valid};
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7 reset valid", longint'(out_valid), 0);
        check(out_frac == '0, "R7 reset data", longint'(out_frac[31:0]), 0);
        @(negedge clk);
        #1 rst = 1'b0;

        // R6: empty groups
        send(0, 0, 0, 0, "R6 zero sum");
        send(0, 0, 0, 0, "R6 zero sum");
        // R1: full scale, no wrap
        send(65535, 65535, 65535, 65535, "R1 all max");
        send(65535, 0, 0, 0, "R1 single max");
        send(0, 0, 0, 65535, "R1 single max lane3");
        send(65535, 65535, 65535, 1, "R1 near max");
        bubble();

        // R2: small totals, zero-padded index, left shift path
        for (int s = 1; s < 64; s++) begin
            send(0, s, 0, 0, "R2 small single");
            if (s % 5 == 0) bubble();
        end
        for (int s = 4; s < 64; s++) spread(s, "R2 small spread");

        // R3: every table index at low, mid and top magnitude
        for (int w = 32; w < 64; w++) begin
            spread(longint'(w), "R3 index p5");
            spread(longint'(w) << 7, "R3 index p12");
            spread(longint'(w) << 12, "R3 index p17");
            send(longint'(w) << 7, 0, 0, 0, "R3 index single");
        end

        // R4: pseudo-random groups of varied magnitude
        for (int i = 0; i < 2400; i++) begin
            longint v [4];
            for (int l = 0; l < 4; l++) begin
                rng = step(rng);
                v[l] = longint'(rng[15:0]) >> rng[19:16];
            end
            send(v[0], v[1], v[2], v[3], "R4 random");
            rng = step(rng);
            if (rng[2:0] == 3'd0) bubble();
        end

        bubble();
        repeat (8) bubble();
        check(rd == wr, "R7 all groups emerged", longint'(rd), longint'(wr));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule